// File: doc/BRIEF.md
# Four-Phase Differential Phase Decoder

This block sits behind a four-phase coherent demodulator. That demodulator delivers two hard-decision bit streams, P and Q, which are aligned to a common symbol clock. For every symbol, the block turns the received bit pair into a phase index from 0 to 3. It then subtracts, modulo 4, the index of the symbol that came immediately before. This undoes the phase-difference coding applied by the transmitter. The recovered two-bit values leave on two output streams, which feed frame alignment and descrambling logic further down the receive path.

One clock beat can carry several consecutive symbols, set by the `LANES` parameter. Lane 0 is the oldest symbol of the beat. The block accepts a new beat every clock and presents the decoded beat one clock later. A valid strobe marks which beats carry symbols. Only valid beats advance the stored reference phase.

Top module: `qpsk_dd_decoder`

## Requirements
- R1: A received pair maps to a phase index as follows (P first, Q second): 00 gives 0, 01 gives 1, 11 gives 2, 10 gives 3. Logic 0 stands for a detected level of -1 and logic 1 for +1.
- R2: Each decoded symbol equals (current index - reference index) mod 4, in natural binary. Its MSB appears on `out_p` and its LSB on `out_q`. The output data registers load on every valid beat.
- R3: `out_valid` rises in the clock after a valid beat, provided a reference phase has already been established.
- R4: While `rst` is high at a clock edge, `out_valid`, `out_p` and `out_q` are cleared to 0 and the reference phase is set to 0.
- R5: The first valid beat after reset produces `out_valid` low. Its last lane still becomes the reference phase for the beat that follows.
- R6: A beat with `in_valid` low drives `out_valid` low in the next clock. It also leaves `out_p`, `out_q` and the reference phase unchanged.
- R7: Within a beat, lane i takes lane i-1 as its reference. Lane 0 takes the last lane of the most recent earlier valid beat as its reference.
- R8: Valid beats may arrive on every clock with no gaps, and each one is decoded.
- R9: The subtraction wraps correctly across the 3-to-0 boundary in both directions. For example, a reference of 3 and a current index of 0 decode to 1, and a reference of 0 and a current index of 3 decode to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-beat clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat carries symbols |
| in_p | input | LANES | P channel bits, lane 0 oldest |
| in_q | input | LANES | Q channel bits, lane 0 oldest |
| out_valid | output | 1 | Decoded beat is meaningful |
| out_p | output | LANES | Decoded MSB per lane |
| out_q | output | LANES | Decoded LSB per lane |

## Verification
The bench builds the decoder with `LANES` set to 2. This setting exercises both kinds of reference: within a beat, lane 1 uses lane 0, and lane 0 of each beat uses the last lane of the previous valid beat. Gaps in the valid strobe test whether that reference survives idle beats. A reset in the middle of the stream brings the first-beat case back. A reference encoder accumulates random two-bit values modulo 4, so runs of large steps drive the phase repeatedly around the wrap point.

// File: rtl/qpsk_dd_pkg.sv
package qpsk_dd_pkg;

    // Quaternary phase index, natural binary 0..3
    typedef logic [1:0] phase_t;

    // One decoded symbol split across the two output streams
    typedef struct packed {
        logic msb;
        logic lsb;
    } dsym_t;

    // Received bit pair to phase index (Gray-ordered constellation)
    function automatic phase_t pq_to_phase(input logic p, input logic q);
        phase_t ph;
        case ({p, q})
            2'b00:   ph = 2'd0;
            2'b01:   ph = 2'd1;
            2'b11:   ph = 2'd2;
            default: ph = 2'd3;
        endcase
        return ph;
    endfunction

    // Modulo-4 difference, current minus reference
    function automatic phase_t phase_sub(input phase_t cur, input phase_t ref_ph);
        phase_t d;
        d = cur - ref_ph;
        return d;
    endfunction

endpackage

// File: rtl/qpsk_dd_map.sv
module qpsk_dd_map
    import qpsk_dd_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic [LANES-1:0]         p_bits,
    input  logic [LANES-1:0]         q_bits,
    output phase_t [LANES-1:0]       phases
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb phases[i] = pq_to_phase(p_bits[i], q_bits[i]);
    end
endmodule

// File: rtl/qpsk_dd_diff.sv
module qpsk_dd_diff
    import qpsk_dd_pkg::*;
#(
    parameter int LANES = 1
) (
    input  phase_t [LANES-1:0] cur_ph,
    input  phase_t             held_ph,
    output dsym_t  [LANES-1:0] dec
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        phase_t ref_ph;
        phase_t d;
        if (i == 0) begin : g_first
            always_comb ref_ph = held_ph;
        end else begin : g_chain
            always_comb ref_ph = cur_ph[i-1];
        end
        always_comb begin
            d          = phase_sub(cur_ph[i], ref_ph);
            dec[i].msb = d[1];
            dec[i].lsb = d[0];
        end
    end
endmodule

// File: rtl/qpsk_dd_state.sv
module qpsk_dd_state
    import qpsk_dd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  phase_t newest_ph,
    output phase_t held_ph,
    output logic   primed
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_ph <= '0;
            primed  <= 1'b0;
        end else if (in_valid) begin
            held_ph <= newest_ph;
            primed  <= 1'b1;
        end
    end
endmodule

// File: rtl/qpsk_dd_decoder.sv
module qpsk_dd_decoder
    import qpsk_dd_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [LANES-1:0] in_p,
    input  logic [LANES-1:0] in_q,
    output logic             out_valid,
    output logic [LANES-1:0] out_p,
    output logic [LANES-1:0] out_q
);
    localparam int LAST = LANES - 1;

    phase_t [LANES-1:0] cur_ph;
    dsym_t  [LANES-1:0] dec;
    phase_t             held_ph;
    logic               primed;

    qpsk_dd_map #(.LANES(LANES)) u_map (
        .p_bits (in_p),
        .q_bits (in_q),
        .phases (cur_ph)
    );

    qpsk_dd_diff #(.LANES(LANES)) u_diff (
        .cur_ph  (cur_ph),
        .held_ph (held_ph),
        .dec     (dec)
    );

    qpsk_dd_state u_state (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .newest_ph (cur_ph[LAST]),
        .held_ph   (held_ph),
        .primed    (primed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_p     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= in_valid & primed;
            if (in_valid) begin
                for (int i = 0; i < LANES; i++) begin
                    out_p[i] <= dec[i].msb;
                    out_q[i] <= dec[i].lsb;
                end
            end
        end
    end
endmodule

// File: rtl/qpsk_dd_chk.sv
module qpsk_dd_chk
    import qpsk_dd_pkg::*;
#(
    parameter int LANES = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [LANES-1:0] in_p,
    input logic [LANES-1:0] in_q,
    input logic             out_valid,
    input logic [LANES-1:0] out_p,
    input logic [LANES-1:0] out_q,
    input phase_t           held_ph,
    input logic             primed
);
    localparam int LAST = LANES - 1;

    assert_reset_clear_R4: assert property (@(posedge clk)
        rst |=> (!out_valid && out_p == '0 && out_q == '0 && held_ph == 2'd0));

    assert_valid_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && primed) |=> out_valid);

    assert_first_beat_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !primed) |=> !out_valid);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_p) && $stable(out_q) && $stable(held_ph)));

    assert_ref_update_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> held_ph == pq_to_phase($past(in_p[LAST]), $past(in_q[LAST])));

    assert_lane0_diff_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> {out_p[0], out_q[0]} ==
            phase_sub(pq_to_phase($past(in_p[0]), $past(in_q[0])), $past(held_ph)));

    for (genvar i = 1; i < LANES; i++) begin : g_lane
        assert_chain_diff_R7: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> {out_p[i], out_q[i]} ==
                phase_sub(pq_to_phase($past(in_p[i]), $past(in_q[i])),
                          pq_to_phase($past(in_p[i-1]), $past(in_q[i-1]))));
    end
endmodule

bind qpsk_dd_decoder qpsk_dd_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_p      (in_p),
    .in_q      (in_q),
    .out_valid (out_valid),
    .out_p     (out_p),
    .out_q     (out_q),
    .held_ph   (held_ph),
    .primed    (primed)
);

// File: tb/sim_qpsk_dd_decoder.sv
module sim_qpsk_dd_decoder;
    localparam int CLK_NS  = 10;
    localparam int LANES_T = 2;
    localparam int WDOG    = 100000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [LANES_T-1:0] in_p = '0;
    logic [LANES_T-1:0] in_q = '0;
    logic               out_valid;
    logic [LANES_T-1:0] out_p;
    logic [LANES_T-1:0] out_q;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Bench reference state
    logic [1:0]         enc_ph = 2'd0;   // transmitter phase accumulator
    bit                 primed_m = 0;
    logic [LANES_T-1:0] exp_p = '0;
    logic [LANES_T-1:0] exp_q = '0;

    qpsk_dd_decoder #(.LANES(LANES_T)) u0 (
        .clk (clk), .rst (rst), .in_valid (in_valid),
        .in_p (in_p), .in_q (in_q),
        .out_valid (out_valid), .out_p (out_p), .out_q (out_q)
    );

    always #(CLK_NS/2) clk = ~clk;

    // Inverse of the R1 mapping: index -> {P,Q}
    function automatic logic [1:0] idx_to_pq(input logic [1:0] ix);
        case (ix)
            2'd0:    return 2'b00;
            2'd1:    return 2'b01;
            2'd2:    return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Called at a falling edge. Drives one beat, waits one clock, checks the outputs.
    // data holds LANES_T two-bit values, lane 0 in bits [1:0].
    task automatic beat(input bit v, input logic [2*LANES_T-1:0] data, input string req);
        bit exp_v;
        if (v) begin
            for (int i = 0; i < LANES_T; i++) begin
                logic [1:0] pq;
                enc_ph = enc_ph + data[2*i +: 2];
                pq = idx_to_pq(enc_ph);
                in_p[i] = pq[1];
                in_q[i] = pq[0];
            end
        end else begin
            in_p = LANES_T'($urandom);
            in_q = LANES_T'($urandom);
        end
        in_valid = v;
        exp_v = v && primed_m;
        if (v) begin
            primed_m = 1;
            for (int i = 0; i < LANES_T; i++) begin
                exp_p[i] = data[2*i+1];
                exp_q[i] = data[2*i];
            end
        end
        @(negedge clk);
        check(out_valid == exp_v, req, "out_valid", int'(out_valid), int'(exp_v));
        check(out_p == exp_p, req, "out_p", int'(out_p), int'(exp_p));
        check(out_q == exp_q, req, "out_q", int'(out_q), int'(exp_q));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        enc_ph = 2'd0;
        primed_m = 0;
        exp_p = '0;
        exp_q = '0;
        check(out_valid == 1'b0, "R4", "out_valid after reset", int'(out_valid), 0);
        check(out_p == '0 && out_q == '0, "R4", "data after reset",
              int'({out_p, out_q}), 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0a17));
        @(negedge clk);
        do_reset();

        // R5: first beat is flagged invalid; R1: from phase 0, lane steps walk the map
        beat(1, {2'd1, 2'd0}, "R5");       // phases 0,1
        beat(1, {2'd1, 2'd1}, "R1");       // phases 2,3
        // R9: step 1 from phase 3 wraps to 0; step 3 then wraps back to 3
        beat(1, {2'd3, 2'd1}, "R9");       // phases 0,3
        beat(1, {2'd2, 2'd3}, "R9");       // phases 2,0
        // R6: idle beats keep data and the reference
        beat(0, '0, "R6");
        beat(0, '0, "R6");
        // R7: lane 0 is referenced to the last lane before the gap
        beat(1, {2'd0, 2'd3}, "R7");
        beat(1, {2'd2, 2'd2}, "R2");
        // R4/R5: reset mid-stream restarts the reference at 0
        in_valid = 1'b1;
        do_reset();
        beat(1, {2'd3, 2'd2}, "R5");
        beat(1, {2'd1, 2'd3}, "R3");

        // R8: back-to-back valid beats; random data and gaps, R2 and R9 throughout
        for (int n = 0; n < 600; n++)
            beat(1, (2*LANES_T)'($urandom), "R8");
        for (int n = 0; n < 3000; n++)
            beat(($urandom % 4) != 0, (2*LANES_T)'($urandom), "R2");
        // R9: runs of all-3 steps cycle the phase around repeatedly
        for (int n = 0; n < 20; n++)
            beat(1, {LANES_T{2'd3}}, "R9");

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < WDOG; c++) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule